// File: doc/BRIEF.md
# Prioritized Interrupt Identifier

This block holds the pending interrupt flags of a message-based bus controller and reports one identifier code to the CPU. There is one status source and `NUM_MSG` message-object sources. Message objects are numbered from 1 to `NUM_MSG`. Each source has its own set pulse input and its own CPU clear strobe. A source's flag stays set until the CPU clears it.

Every cycle the block picks the most urgent pending source and registers its code into the identifier output. The order in which events arrived plays no part in this choice. The status source has the highest rank. Among message objects, a lower object number has a higher rank. The block also drives a single interrupt request line. This line is the OR of all pending flags, gated by a global enable input.

Top module: `irq_ident_top`

## Requirements
- R1: While reset is asserted and right after its release, `irq_id_o` is 0x0000 and `irq_o` is 0.
- R2: A set pulse on a source makes that source pending from the next rising edge. The source stays pending until a clear for it is seen. Message object n uses bit n-1 of `msg_set_i` and `msg_clr_i`.
- R3: A clear strobe on a pending source, with no set pulse for the same source in that cycle, removes its pending flag at the next rising edge.
- R4: If a set pulse and a clear strobe hit the same source in the same cycle, the source is pending after that edge.
- R5: While the status source is pending, the identifier reports 0x8000, whatever message objects are also pending.
- R6: With the status source idle and at least one message object pending, the identifier reports the lowest pending object number, as an unsigned value in bits 15:0.
- R7: With nothing pending, the identifier reports 0x0000.
- R8: The identifier is registered. It reflects the pending set as it stood before the most recent rising edge. After the reported source is cleared, the identifier moves to the next source in rank one clock later.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one source is pending. `irq_en_i` changes neither the pending flags nor the identifier.
- R10: Two sources set in either order produce the same identifier once both are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_set_i | input | NUM_MSG | Per-object event pulse; bit n-1 is object n |
| msg_clr_i | input | NUM_MSG | Per-object CPU clear strobe |
| stat_set_i | input | 1 | Status event pulse |
| stat_clr_i | input | 1 | CPU clear strobe for the status source |
| irq_en_i | input | 1 | Global interrupt request enable |
| irq_id_o | output | 16 | Code of the highest-ranked pending source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a source's event pulse and the CPU's clear for that same source. The bench provokes this collision on purpose for a message object and for the status source. It also overlays random set and clear vectors, so that collisions happen on many bits at once. It judges each case by whether the source is still pending afterwards, seen through the identifier one clock later and through the request line, and compares this against a flag model in the bench in which the set wins.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
  localparam int unsigned ID_W      = 16;
  localparam logic [ID_W-1:0] STAT_CODE = 16'h8000;
  localparam logic [ID_W-1:0] NONE_CODE = 16'h0000;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[k]) flag_q <= 1'b1;   // set wins over clear
      else if (clr_i[k]) flag_q <= 1'b0;
    end
    assign pend_o[k] = flag_q;

    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[k] && clr_i[k]) |=> pend_o[k]);
    a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && !clr_i[k]) |=> pend_o[k]);
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int unsigned N   = 32,
  localparam int unsigned NUM_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec_i,
  output logic             hit_o,
  output logic [NUM_W-1:0] num_o   // 1-based position of lowest set bit
);
  always_comb begin
    num_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) num_o = NUM_W'(k + 1);
    end
  end
  assign hit_o = |vec_i;
endmodule

// File: rtl/irq_id_reg.sv
module irq_id_reg
  import irq_ident_pkg::*;
#(
  parameter int unsigned NUM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stat_pend_i,
  input  logic             msg_hit_i,
  input  logic [NUM_W-1:0] msg_num_i,
  output logic [ID_W-1:0]  id_o
);
  logic [ID_W-1:0] id_d, id_q;

  always_comb begin
    if (stat_pend_i)    id_d = STAT_CODE;
    else if (msg_hit_i) id_d = ID_W'(msg_num_i);
    else                id_d = NONE_CODE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= NONE_CODE;
    else         id_q <= id_d;
  end
  assign id_o = id_q;

  a_r5_status_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pend_i |=> (id_o == STAT_CODE));
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_pend_i && !msg_hit_i) |=> (id_o == NONE_CODE));
endmodule

// File: rtl/irq_ident_top.sv
module irq_ident_top
  import irq_ident_pkg::*;
#(
  parameter int unsigned NUM_MSG = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MSG-1:0] msg_set_i,
  input  logic [NUM_MSG-1:0] msg_clr_i,
  input  logic               stat_set_i,
  input  logic               stat_clr_i,
  input  logic               irq_en_i,
  output logic [15:0]        irq_id_o,
  output logic               irq_o
);
  localparam int unsigned NSRC  = NUM_MSG + 1;
  localparam int unsigned NUM_W = $clog2(NUM_MSG + 1);

  logic [NSRC-1:0]  pend;
  logic             msg_hit;
  logic [NUM_W-1:0] msg_num;

  // bit NUM_MSG is the status source
  irq_pend_bank #(.N(NSRC)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({stat_set_i, msg_set_i}),
    .clr_i  ({stat_clr_i, msg_clr_i}),
    .pend_o (pend)
  );

  irq_first_set #(.N(NUM_MSG)) i_first (
    .vec_i (pend[NUM_MSG-1:0]),
    .hit_o (msg_hit),
    .num_o (msg_num)
  );

  irq_id_reg #(.NUM_W(NUM_W)) i_id (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_pend_i (pend[NUM_MSG]),
    .msg_hit_i   (msg_hit),
    .msg_num_i   (msg_num),
    .id_o        (irq_id_o)
  );

  assign irq_o = irq_en_i & (|pend);

  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);
  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_id_o == STAT_CODE) || (irq_id_o <= 16'(NUM_MSG)));
  a_r6_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend[NUM_MSG] && pend[0]) |=> (irq_id_o == 16'd1));
endmodule

// File: tb/test_irq_ident_top.sv
module test_irq_ident_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] msg_set = '0, msg_clr = '0;
  logic         stat_set = 1'b0, stat_clr = 1'b0, en = 1'b0;
  logic [15:0]  id;
  logic         irq;

  int checks = 0, fails = 0;
  logic [N:0]   m_pend = '0;
  logic [15:0]  m_id = '0;

  always #5 clk = ~clk;

  irq_ident_top #(.NUM_MSG(N)) i_irq_ident_top (
    .clk_i(clk), .rst_ni(rst_n), .msg_set_i(msg_set), .msg_clr_i(msg_clr),
    .stat_set_i(stat_set), .stat_clr_i(stat_clr), .irq_en_i(en),
    .irq_id_o(id), .irq_o(irq)
  );

  function automatic logic [15:0] code_of(input logic [N:0] p);
    if (p[N]) return 16'h8000;
    for (int k = 0; k < N; k++) if (p[k]) return 16'(k + 1);
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, check after the edge
  task automatic step(input string req, input logic [N-1:0] ms, mc,
                      input logic ss, sc, e);
    @(negedge clk);
    msg_set = ms; msg_clr = mc; stat_set = ss; stat_clr = sc; en = e;
    @(posedge clk);
    m_id   = code_of(m_pend);
    m_pend = (m_pend & ~{sc, mc}) | {ss, ms};
    #2;
    chk({req, " id"}, id, m_id);
    chk({req, " irq"}, {15'd0, irq}, {15'd0, e & (|m_pend)});
  endtask

  function automatic logic [N-1:0] obj(input int n);
    return N'(1) << (n - 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 id in reset", id, 16'h0000);
    chk("R1 irq in reset", {15'd0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 id after reset", id, 16'h0000);

    // R2/R10: arrival order 20 then 7, and 7 then 20
    step("R2 set 20", obj(20), '0, 0, 0, 1);
    step("R10 set 7", obj(7), '0, 0, 0, 1);
    step("R10 hold", '0, '0, 0, 0, 1);
    chk("R10 id 7", id, 16'd7);
    step("R3 clr 7", '0, obj(7), 0, 0, 1);
    step("R8 next 20", '0, '0, 0, 0, 1);
    chk("R8 moves to 20", id, 16'd20);
    step("R3 clr 20", '0, obj(20), 0, 0, 1);
    step("R10 set 7", obj(7), '0, 0, 0, 1);
    step("R10 set 20", obj(20), '0, 0, 0, 1);
    step("R10 hold", '0, '0, 0, 0, 1);
    chk("R10 id 7 reversed", id, 16'd7);
    // R5: status outranks, then R8 fall back
    step("R5 status", '0, '0, 1, 0, 1);
    step("R5 hold", obj(1), '0, 0, 0, 1);
    chk("R5 id 8000", id, 16'h8000);
    step("R8 clr status", '0, '0, 0, 1, 1);
    chk("R8 still 8000", id, 16'h8000);
    step("R8 next", '0, '0, 0, 0, 1);
    chk("R6 lowest 1", id, 16'd1);
    // R4: collision on object 32 and on status
    step("R4 collide 32", obj(32) | obj(1), obj(32) | obj(1), 1, 1, 1);
    step("R4 clr others", '0, obj(7) | obj(20), 0, 0, 1);
    step("R4 clr 1", '0, obj(1), 0, 1, 1);
    step("R4 clr 1 wait", '0, '0, 0, 0, 1);
    chk("R4 32 pending", id, 16'd32);
    // R9: enable low
    step("R9 en low", '0, '0, 0, 0, 0);
    chk("R9 irq low", {15'd0, irq}, 16'h0000);
    chk("R9 id kept", id, 16'd32);
    step("R7 clr 32", '0, obj(32), 0, 0, 1);
    step("R7 empty", '0, '0, 0, 0, 1);
    chk("R7 id zero", id, 16'h0000);

    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] ms, mc;
      logic ss, sc, e;
      ms = $urandom & $urandom & $urandom & $urandom;
      mc = $urandom & $urandom & $urandom;
      if (i % 5 == 0) mc = mc | obj(int'(code_of({1'b0, m_pend[N-1:0]})) == 0 ? 1
                                   : int'(code_of({1'b0, m_pend[N-1:0]})));
      ss = ($urandom % 8) == 0;
      sc = ($urandom % 4) == 0;
      e  = ($urandom % 4) != 0;
      step("R2-R9 random", ms, mc, ss, sc, e);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule